// File: doc/BRIEF.md
# General-Purpose I/O Port with Change Interrupt

This block is an 8-bit bidirectional I/O port for a small microcontroller. Each pin has a direction bit and an output latch bit. A read of the port returns the levels on the pins after a two-flop synchronizer, not the contents of the latch. The control register has one global active-low bit that turns on weak pull-ups. A pull-up is on only for a pin configured as an input.

The upper four pins can raise an interrupt. Whenever software reads or writes the port, the block stores a snapshot of the synchronized pins. Any upper pin that is an input and differs from its snapshot value sets a sticky flag. The same flag drives the interrupt output and a wake request for a sleep controller. The flag is set again on every cycle that the mismatch remains. Software must therefore access the port, which refreshes the snapshot, before a clear of the flag takes effect.

Address map (3-bit address):

| Address | Register | Description |
|---|---|---|
| 0 | port | read: pin levels; write: output latch |
| 1 | direction | 1 = input, 0 = output |
| 2 | control | bit 7 = pull-up disable (active low enable), bit 0 = change flag |
| 3 | bit set | latch <= pins OR data |
| 4 | bit clear | latch <= pins AND NOT data |

Top module: `gpio_chg_port`

## Requirements
- R1: After reset:
  - the direction register reads 0xFF;
  - the control register reads 0x80 (pull-ups disabled, flag clear);
  - `pin_out`, `pin_oe`, `pin_pu_en`, `irq_flag` and `wake_req` are all zero.
- R2: A direction bit of 1 makes that pin an input (`pin_oe` bit 0). A direction bit of 0 drives the pin from the matching latch bit (`pin_oe` bit 1, `pin_out` = latch).
- R3: A write to address 0 loads the output latch. A read of address 0 returns the pin levels through a two-stage synchronizer, for input pins and for output pins alike.
- R4: A write to address 3 loads the latch with (synchronized pins OR data). A write to address 4 loads it with (synchronized pins AND NOT data). Both use the pin levels, not the old latch value.
- R5: Clearing control bit 7 enables the pull-up on every input pin. A pin configured as an output never has its pull-up enabled. Setting bit 7 turns all pull-ups off.
- R6: Only pins 7 to 4 configured as inputs are compared with the snapshot. A change on pins 3 to 0, or on any output pin, never sets the flag.
- R7: Any read or write at address 0, 3 or 4 loads the snapshot with the current synchronized pins.
- R8: The flag is set on every cycle in which a mismatch exists and no snapshot is being taken. Writing control bit 0 as 0 clears the flag only when no mismatch is present; a live mismatch wins. Writing bit 0 as 1 has no effect.
- R9: When the synchronized pin value changes in the same cycle as a snapshot-capturing access, the new value is captured and the flag is not set.
- R10: `irq_flag` and `wake_req` both follow the flag and assert together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational on addr) |
| pin_in | input | 8 | Raw pin levels (asynchronous) |
| pin_out | output | 8 | Output latch value to the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pu_en | output | 8 | Per-pin weak pull-up enable |
| irq_flag | output | 1 | Change interrupt flag |
| wake_req | output | 1 | Wake request to the sleep controller |

## Verification
The bench checks a bit-set on a port where some input pins sit low under latch bits that hold 1. A design that merged the mask with the latch instead of the pins would leave those bits high.

It tries to clear the flag while the mismatch is still present. A design whose software clear beat the set, or whose detector compared against the previous clock sample, would drop the flag early.

It toggles output pins in the upper nibble and input pins in the lower nibble. Either change would raise a false interrupt in a design that did not mask them.

Last, it times a pin change to land in the same cycle as a port read. A design that compared before it captured would report a spurious flag.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
   localparam int unsigned REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_PORT = 3'd0,
      RA_DIR  = 3'd1,
      RA_CTRL = 3'd2,
      RA_SET  = 3'd3,
      RA_CLR  = 3'd4
   } reg_addr_e;

   localparam int unsigned CTRL_FLAG_BIT = 0;
endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("gpio_sync_chain: STAGES must be at least 1");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
   parameter int unsigned NBITS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] pin_hi,
   input  logic [NBITS-1:0] dir_hi,
   input  logic             cap,
   input  logic             clr_req,
   output logic             flag
);
   logic [NBITS-1:0] snap_q;
   logic [NBITS-1:0] mm;
   logic             set_now;

   generate
      if (NBITS < 1) begin : g_bad_nbits
         $error("gpio_chg_detect: NBITS must be at least 1");
      end
      for (genvar i = 0; i < NBITS; i++) begin : g_cmp
         assign mm[i] = dir_hi[i] & (pin_hi[i] ^ snap_q[i]);
      end
   endgenerate

   // a capture cycle takes the new value and suppresses the compare
   assign set_now = (|mm) & ~cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   snap_q <= '0;
      else if (cap) snap_q <= pin_hi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (set_now)  flag <= 1'b1;
      else if (clr_req)  flag <= 1'b0;
   end

   // R8
   mm_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_now |=> flag);
   // R9
   cap_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && !flag) |=> !flag);
   // R8
   clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(clr_req));
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
   import gpio_chg_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned CHG_LO      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe,
   output logic [WIDTH-1:0]  pin_pu_en,
   output logic              irq_flag,
   output logic              wake_req
);
   localparam int unsigned HI_W   = WIDTH - CHG_LO;
   localparam int unsigned PU_BIT = WIDTH - 1;

   generate
      if (WIDTH < 2 || CHG_LO >= WIDTH) begin : g_bad_cfg
         $error("gpio_chg_port: CHG_LO must lie below WIDTH");
      end
   endgenerate

   reg_addr_e        ra;
   logic [WIDTH-1:0] pin_s;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] lat_q;
   logic             pu_dis_q;
   logic             port_addr;
   logic             port_wr;
   logic             cap;
   logic             clr_req;
   logic             flag;

   assign ra        = reg_addr_e'(addr);
   assign port_addr = (ra == RA_PORT) || (ra == RA_SET) || (ra == RA_CLR);
   assign port_wr   = wr_en && port_addr;
   assign cap       = (wr_en || rd_en) && port_addr;
   assign clr_req   = wr_en && (ra == RA_CTRL) && !wdata[CTRL_FLAG_BIT];

   gpio_sync_chain #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q    <= '1;
         lat_q    <= '0;
         pu_dis_q <= 1'b1;
      end else if (wr_en) begin
         case (ra)
            RA_PORT: lat_q    <= wdata;
            RA_SET:  lat_q    <= pin_s | wdata;
            RA_CLR:  lat_q    <= pin_s & ~wdata;
            RA_DIR:  dir_q    <= wdata;
            RA_CTRL: pu_dis_q <= wdata[PU_BIT];
            default: ;
         endcase
      end
   end

   gpio_chg_detect #(.NBITS(HI_W)) u_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_hi  (pin_s[WIDTH-1:CHG_LO]),
      .dir_hi  (dir_q[WIDTH-1:CHG_LO]),
      .cap     (cap),
      .clr_req (clr_req),
      .flag    (flag)
   );

   always_comb begin
      rdata = '0;
      case (ra)
         RA_PORT: rdata = pin_s;
         RA_DIR:  rdata = dir_q;
         RA_CTRL: begin
            rdata[PU_BIT]        = pu_dis_q;
            rdata[CTRL_FLAG_BIT] = flag;
         end
         default: rdata = '0;
      endcase
   end

   assign pin_out   = lat_q;
   assign pin_oe    = ~dir_q;
   assign pin_pu_en = pu_dis_q ? '0 : dir_q;
   assign irq_flag  = flag;
   assign wake_req  = flag;

   // R2
   oe_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_oe) |-> $past(wr_en && ra == RA_DIR));
   // R3
   latch_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_out) |-> $past(port_wr));
   // R5
   pu_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_pu_en) |-> $past(wr_en && (ra == RA_DIR || ra == RA_CTRL)));
endmodule

// File: tb/gpio_chg_port_bench.sv
module gpio_chg_port_bench;
   import gpio_chg_pkg::*;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [REG_AW-1:0] addr = '0;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [7:0]        wdata = '0;
   logic [7:0]        rdata;
   logic [7:0]        pin_in;
   logic [7:0]        pin_out;
   logic [7:0]        pin_oe;
   logic [7:0]        pin_pu_en;
   logic              irq_flag;
   logic              wake_req;
   logic [7:0]        ext = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

   gpio_chg_port u_gpio_chg_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .wdata     (wdata),
      .rdata     (rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .pin_pu_en (pin_pu_en),
      .irq_flag  (irq_flag),
      .wake_req  (wake_req)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic quiesce();
      logic [7:0] v;
      ext = 8'h00;
      bus_wr(RA_DIR, 8'hFF);
      settle();
      bus_rd(RA_PORT, v);
      bus_wr(RA_CTRL, 8'h80);
      check("quiesce R8 flag clear", {7'd0, irq_flag}, 8'h00);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      @(negedge clk);
      check("R1 pin_out", pin_out, 8'h00);
      check("R1 pin_oe", pin_oe, 8'h00);
      check("R1 pin_pu_en", pin_pu_en, 8'h00);
      check("R1 irq/wake", {6'd0, wake_req, irq_flag}, 8'h00);
      bus_rd(RA_DIR, v);
      check("R1 dir reg", v, 8'hFF);
      bus_rd(RA_CTRL, v);
      check("R1 ctrl reg", v, 8'h80);
   endtask

   task automatic t_dir_out();
      logic [7:0] v;
      bus_wr(RA_DIR, 8'h0F);
      check("R2 oe", pin_oe, 8'hF0);
      bus_wr(RA_PORT, 8'hA5);
      check("R2 pin_out", pin_out, 8'hA5);
      ext = 8'h0C;
      settle();
      bus_rd(RA_PORT, v);
      check("R3 readback mixed", v, 8'hAC);
      bus_wr(RA_PORT, 8'h05);
      settle();
      bus_rd(RA_PORT, v);
      check("R3 readback output toggle", v, 8'h0C);
      check("R6 output pins no flag", {7'd0, irq_flag}, 8'h00);
   endtask

   task automatic t_rmw();
      bus_wr(RA_DIR, 8'h0F);
      ext = 8'h0C;
      bus_wr(RA_PORT, 8'hFF);
      settle();
      bus_wr(RA_SET, 8'h10);
      check("R4 set uses pins", pin_out, 8'hFC);
      settle();
      bus_wr(RA_CLR, 8'h80);
      check("R4 clear uses pins", pin_out, 8'h7C);
      quiesce();
   endtask

   task automatic t_pullup();
      logic [7:0] v;
      bus_wr(RA_DIR, 8'h3C);
      bus_wr(RA_CTRL, 8'h00);
      check("R5 pull-ups on inputs only", pin_pu_en, 8'h3C);
      bus_rd(RA_CTRL, v);
      check("R5 ctrl readback", v, 8'h00);
      bus_wr(RA_CTRL, 8'h80);
      check("R5 pull-ups off", pin_pu_en, 8'h00);
      quiesce();
   endtask

   task automatic t_change();
      logic [7:0] v;
      ext = 8'h20;
      settle();
      check("R6 flag on input change", {7'd0, irq_flag}, 8'h01);
      check("R10 wake follows flag", {7'd0, wake_req}, 8'h01);
      bus_wr(RA_CTRL, 8'h80);
      check("R8 clear blocked by mismatch", {7'd0, irq_flag}, 8'h01);
      bus_rd(RA_PORT, v);
      check("R7 port read value", v, 8'h20);
      bus_wr(RA_CTRL, 8'h80);
      check("R8 clear after read", {7'd0, irq_flag}, 8'h00);
      check("R10 wake clear", {7'd0, wake_req}, 8'h00);
      bus_wr(RA_CTRL, 8'h81);
      check("R8 write one no effect", {7'd0, irq_flag}, 8'h00);
      ext = 8'h22;
      settle();
      check("R6 low nibble ignored", {7'd0, irq_flag}, 8'h00);
      ext = 8'h32;
      settle();
      check("R6 bit4 change flags", {7'd0, irq_flag}, 8'h01);
      bus_wr(RA_PORT, 8'h00);
      bus_wr(RA_CTRL, 8'h80);
      check("R7 port write refreshes snapshot", {7'd0, irq_flag}, 8'h00);
      quiesce();
   endtask

   task automatic t_collision();
      logic [7:0] v;
      @(negedge clk);
      ext = 8'h10;
      @(negedge clk);
      @(negedge clk);
      addr = RA_PORT; rd_en = 1'b1;
      #1 v = rdata;
      @(negedge clk);
      rd_en = 1'b0;
      check("R9 read sees new value", v, 8'h10);
      settle();
      check("R9 no flag on collision", {7'd0, irq_flag}, 8'h00);
      bus_rd(RA_PORT, v);
      check("R9 snapshot holds new value", {7'd0, irq_flag}, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_dir_out();
      t_rmw();
      t_pullup();
      quiesce();
      t_change();
      t_collision();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule